// File: doc/BRIEF.md
# High-Speed Data Lane Burst Sequencer

This block walks a single transmit data lane through one high-speed burst. At rest the lane sits in the LP-11 stop state. When a burst is requested, the block waits for the clock lane to report that it is running. It then drives the low-power request and bridge states and holds HS-0 for a zero period. After that it emits a sync byte and forwards payload bytes from a valid/ready source. When the source stops offering data, it drives a trail pattern and returns to LP-11 for an exit period before accepting the next request.

Every output is a 3-bit line-state code plus a parallel byte with a valid strobe, both meant for an external serializer. Each interval is a programmable count of clock cycles, held on configuration inputs. A separate flag reports a programmed trail that is longer than the end-of-transmission bound, also given in cycles.

States of the sequencer: IDLE (LP-11, not busy), WAIT_CLK (LP-11, waiting for clock ready), REQUEST (LP-01), PREPARE (LP-00), ZERO (HS-0), SYNC (sync byte), PAYLOAD (byte transfer), TRAIL (inverted last bit), EXIT (LP-11, busy). Transitions:
- IDLE goes to WAIT_CLK on start.
- WAIT_CLK goes to REQUEST on clk_ready.
- REQUEST, PREPARE, ZERO, TRAIL and EXIT each move to the next state when their interval expires. EXIT returns to IDLE.
- SYNC always goes to PAYLOAD after one cycle.
- PAYLOAD goes to TRAIL when valid is low and at least one byte has already moved.

Top module: `lane_burst_seq`

## Requirements
- R1: The line-state codes are 0 = LP-11, 1 = LP-01, 2 = LP-00, 3 = HS-0, 4 = HS data and 5 = HS trail. During and after reset, the block drives code 0 with busy, pay_ready and hs_valid all low. Whenever busy is low, the line state is 0.
- R2: A start seen while idle raises busy on the next cycle. The lane then stays at code 0 until clk_ready is sampled high.
- R3: The request state drives code 1 for cfg_lpx cycles, with 0 treated as 1. It follows LP-11 directly.
- R4: The prepare state drives code 2 for cfg_prep cycles, with 0 treated as 1. It follows the request state.
- R5: The zero state drives code 3 for cfg_zero cycles, with 0 treated as 1. It follows the prepare state.
- R6: Right after the zero state, the block spends exactly one cycle at code 4 with hs_valid high and hs_byte = 8'hB8.
- R7: In the payload state, the block drives code 4 with pay_ready high. A byte offered with pay_valid high appears on hs_byte with hs_valid high in the same cycle. Low valid before the first byte stalls the lane with hs_valid low. Low valid after at least one byte ends the payload after that cycle.
- R8: The trail state drives code 5 for cfg_trail cycles, with 0 treated as 1. Throughout the trail, hs_valid is high and every bit of hs_byte equals the inverse of bit 7 of the last byte sent. Bit 7 is the bit serialized last.
- R9: After the trail, the lane drives code 0 with busy high for cfg_exit cycles, with 0 treated as 1. It then returns to idle with busy low.
- R10: cfg_err is high exactly when cfg_trail is greater than cfg_eot_max.
- R11: A start held high while busy has no effect on the sequence and does not extend busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Burst request, sampled while idle |
| clk_ready | input | 1 | Clock lane is running in high-speed mode |
| cfg_lpx | input | CNT_W | Request interval, cycles |
| cfg_prep | input | CNT_W | Prepare interval, cycles |
| cfg_zero | input | CNT_W | Zero interval, cycles |
| cfg_trail | input | CNT_W | Trail interval, cycles |
| cfg_exit | input | CNT_W | Exit interval, cycles |
| cfg_eot_max | input | CNT_W | Upper bound for the trail, cycles |
| pay_valid | input | 1 | Payload byte offered |
| pay_data | input | 8 | Payload byte |
| pay_ready | output | 1 | Payload byte accepted when valid |
| line_state | output | 3 | Lane line-state code |
| hs_valid | output | 1 | hs_byte carries a byte for the serializer |
| hs_byte | output | 8 | Parallel byte toward the serializer |
| busy | output | 1 | Burst in progress |
| cfg_err | output | 1 | Trail exceeds the end-of-transmission bound |

## Verification
The assertions assume that the configuration inputs stay constant while busy is high, and that pay_data is stable whenever pay_valid is high. The bench changes configuration only between bursts, at the falling edge while the block is idle. It drives every input from a precomputed per-cycle script, so payload bytes, stalls, the delayed clk_ready and the held start line all change only at falling edges.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;

    typedef enum logic [2:0] {
        LN_STOP     = 3'd0,
        LN_REQ      = 3'd1,
        LN_BRIDGE   = 3'd2,
        LN_HS_ZERO  = 3'd3,
        LN_HS_DATA  = 3'd4,
        LN_HS_TRAIL = 3'd5
    } lane_line_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_CLK,
        ST_REQUEST,
        ST_PREPARE,
        ST_ZERO,
        ST_SYNC,
        ST_PAYLOAD,
        ST_TRAIL,
        ST_EXIT
    } seq_state_e;

    localparam logic [7:0] SYNC_BYTE = 8'hB8;

endpackage

// File: rtl/lane_interval_timer.sv
module lane_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // A load of N gives N cycles before expiry; 0 behaves as 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lane_cfg_check.sv
module lane_cfg_check #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] trail_cycles,
    input  logic [CNT_W-1:0] eot_limit,
    output logic             too_long
);
    always_comb begin
        too_long = (trail_cycles > eot_limit);
    end
endmodule

// File: rtl/lane_burst_seq.sv
module lane_burst_seq
    import lane_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clk_ready,
    input  logic [CNT_W-1:0] cfg_lpx,
    input  logic [CNT_W-1:0] cfg_prep,
    input  logic [CNT_W-1:0] cfg_zero,
    input  logic [CNT_W-1:0] cfg_trail,
    input  logic [CNT_W-1:0] cfg_exit,
    input  logic [CNT_W-1:0] cfg_eot_max,
    input  logic             pay_valid,
    input  logic [7:0]       pay_data,
    output logic             pay_ready,
    output logic [2:0]       line_state,
    output logic             hs_valid,
    output logic [7:0]       hs_byte,
    output logic             busy,
    output logic             cfg_err
);
    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] interval_d;
    logic             phase_load;
    logic             phase_done;
    logic             got_first_q;
    logic [7:0]       last_byte_q;
    lane_line_e       line_d;

    lane_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (interval_d),
        .expired  (phase_done)
    );

    lane_cfg_check #(.CNT_W(CNT_W)) u_cfg (
        .trail_cycles (cfg_trail),
        .eot_limit    (cfg_eot_max),
        .too_long     (cfg_err)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)                     state_d = ST_WAIT_CLK;
            ST_WAIT_CLK: if (clk_ready)                 state_d = ST_REQUEST;
            ST_REQUEST:  if (phase_done)                state_d = ST_PREPARE;
            ST_PREPARE:  if (phase_done)                state_d = ST_ZERO;
            ST_ZERO:     if (phase_done)                state_d = ST_SYNC;
            ST_SYNC:                                    state_d = ST_PAYLOAD;
            ST_PAYLOAD:  if (!pay_valid && got_first_q) state_d = ST_TRAIL;
            ST_TRAIL:    if (phase_done)                state_d = ST_EXIT;
            ST_EXIT:     if (phase_done)                state_d = ST_IDLE;
            default:                                    state_d = ST_IDLE;
        endcase
    end

    // Interval loaded on entry into a timed state.
    always_comb begin
        interval_d = '0;
        unique case (state_d)
            ST_REQUEST: interval_d = cfg_lpx;
            ST_PREPARE: interval_d = cfg_prep;
            ST_ZERO:    interval_d = cfg_zero;
            ST_TRAIL:   interval_d = cfg_trail;
            ST_EXIT:    interval_d = cfg_exit;
            default:    interval_d = '0;
        endcase
    end

    assign phase_load = (state_d != state_q);

    // State register plus payload bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            got_first_q <= 1'b0;
            last_byte_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SYNC) begin
                got_first_q <= 1'b0;
                last_byte_q <= SYNC_BYTE;
            end else if (state_q == ST_PAYLOAD && pay_valid) begin
                got_first_q <= 1'b1;
                last_byte_q <= pay_data;
            end
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        line_d    = LN_STOP;
        busy      = 1'b1;
        pay_ready = 1'b0;
        hs_valid  = 1'b0;
        hs_byte   = '0;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_WAIT_CLK: line_d = LN_STOP;
            ST_REQUEST:  line_d = LN_REQ;
            ST_PREPARE:  line_d = LN_BRIDGE;
            ST_ZERO:     line_d = LN_HS_ZERO;
            ST_SYNC: begin
                line_d   = LN_HS_DATA;
                hs_valid = 1'b1;
                hs_byte  = SYNC_BYTE;
            end
            ST_PAYLOAD: begin
                line_d    = LN_HS_DATA;
                pay_ready = 1'b1;
                hs_valid  = pay_valid;
                hs_byte   = pay_valid ? pay_data : 8'h00;
            end
            ST_TRAIL: begin
                line_d   = LN_HS_TRAIL;
                hs_valid = 1'b1;
                hs_byte  = {8{~last_byte_q[7]}};
            end
            ST_EXIT:     line_d = LN_STOP;
            default:     busy = 1'b0;
        endcase
    end

    assign line_state = line_d;
endmodule

// File: rtl/lane_seq_chk.sv
module lane_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       pay_ready,
    input logic [2:0] line_state,
    input logic       hs_valid,
    input logic [7:0] hs_byte
);
    AST_IDLE_IS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_state == 3'd0);                                       // R1
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);                                          // R2
    AST_REQ_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd1 && $past(line_state) != 3'd1) |-> $past(line_state) == 3'd0); // R3
    AST_PREP_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd2 && $past(line_state) != 3'd2) |-> $past(line_state) == 3'd1); // R4
    AST_ZERO_FROM_PREP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd3 && $past(line_state) != 3'd3) |-> $past(line_state) == 3'd2); // R5
    AST_SYNC_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd4 && $past(line_state) == 3'd3) |-> (hs_valid && hs_byte == 8'hB8)); // R6
    AST_READY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> line_state == 3'd4);                                   // R7
    AST_TRAIL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd5 && $past(line_state) == 3'd5) |-> $stable(hs_byte)); // R8
    AST_TRAIL_TO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd0 && $past(line_state) == 3'd5) |-> busy);         // R9
endmodule

bind lane_burst_seq lane_seq_chk u_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .pay_ready  (pay_ready),
    .line_state (line_state),
    .hs_valid   (hs_valid),
    .hs_byte    (hs_byte)
);

// File: tb/tb_lane_burst_seq.sv
module tb_lane_burst_seq;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             clk_ready = 1'b0;
    logic [CNT_W-1:0] cfg_lpx = '0, cfg_prep = '0, cfg_zero = '0;
    logic [CNT_W-1:0] cfg_trail = '0, cfg_exit = '0, cfg_eot_max = '0;
    logic             pay_valid = 1'b0;
    logic [7:0]       pay_data = '0;
    logic             pay_ready, hs_valid, busy, cfg_err;
    logic [2:0]       line_state;
    logic [7:0]       hs_byte;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lane_burst_seq #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_ready(clk_ready),
        .cfg_lpx(cfg_lpx), .cfg_prep(cfg_prep), .cfg_zero(cfg_zero),
        .cfg_trail(cfg_trail), .cfg_exit(cfg_exit), .cfg_eot_max(cfg_eot_max),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
        .line_state(line_state), .hs_valid(hs_valid), .hs_byte(hs_byte),
        .busy(busy), .cfg_err(cfg_err)
    );

    // One cycle of the reference timeline: inputs to drive and outputs expected.
    typedef struct {
        bit         st, cr, pv;
        logic [7:0] pd;
        logic [2:0] ls;
        bit         bz, rd, vd;
        logic [7:0] by;
        int         rq;
    } ent_t;

    function automatic ent_t mk(bit st, bit cr, bit pv, logic [7:0] pd, logic [2:0] ls,
                                bit bz, bit rd, bit vd, logic [7:0] by, int rq);
        ent_t e;
        e.st = st; e.cr = cr; e.pv = pv; e.pd = pd; e.ls = ls;
        e.bz = bz; e.rd = rd; e.vd = vd; e.by = by; e.rq = rq;
        return e;
    endfunction

    function automatic int atleast1(int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic check(bit ok, int rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Builds the expected timeline of a burst from the requirements, then
    // replays it one cycle at a time.
    task automatic run_burst(int lpx, int prep, int zero, int trl, int ext,
                             int nb, int seed, int dly, int gap, bit hold);
        ent_t q[$];
        logic [7:0] last;
        logic [7:0] b;
        bit hs;
        hs = hold;
        @(negedge clk);
        cfg_lpx = lpx[7:0]; cfg_prep = prep[7:0]; cfg_zero = zero[7:0];
        cfg_trail = trl[7:0]; cfg_exit = ext[7:0];
        q.push_back(mk(1, 0, 0, 0, 3'd0, 0, 0, 0, 0, 2));                   // R2 idle sample
        for (int i = 0; i <= dly; i++)
            q.push_back(mk(hs, i == dly, 0, 0, 3'd0, 1, 0, 0, 0, 2));       // R2 waiting
        for (int i = 0; i < atleast1(lpx); i++)
            q.push_back(mk(hs, 1, 0, 0, 3'd1, 1, 0, 0, 0, 3));              // R3
        for (int i = 0; i < atleast1(prep); i++)
            q.push_back(mk(hs, 1, 0, 0, 3'd2, 1, 0, 0, 0, 4));              // R4
        for (int i = 0; i < atleast1(zero); i++)
            q.push_back(mk(hs, 1, 0, 0, 3'd3, 1, 0, 0, 0, 5));              // R5
        q.push_back(mk(hs, 1, 0, 0, 3'd4, 1, 0, 1, 8'hB8, 6));              // R6
        for (int i = 0; i < gap; i++)
            q.push_back(mk(hs, 1, 0, 0, 3'd4, 1, 1, 0, 0, 7));              // R7 stall
        last = 8'hB8;
        for (int k = 0; k < nb; k++) begin
            b = 8'(seed + k * 37);
            q.push_back(mk(hs, 1, 1, b, 3'd4, 1, 1, 1, b, 7));              // R7 transfer
            last = b;
        end
        q.push_back(mk(hs, 1, 0, 0, 3'd4, 1, 1, 0, 0, 7));                  // R7 end
        for (int i = 0; i < atleast1(trl); i++)
            q.push_back(mk(hs, 1, 0, 0, 3'd5, 1, 0, 1, {8{~last[7]}}, 8));  // R8
        for (int i = 0; i < atleast1(ext); i++)
            q.push_back(mk(hs, 1, 0, 0, 3'd0, 1, 0, 0, 0, 9));              // R9
        q.push_back(mk(0, 0, 0, 0, 3'd0, 0, 0, 0, 0, hold ? 11 : 9));       // R9 / R11 idle again

        foreach (q[i]) begin
            if (i != 0) @(negedge clk);
            start = q[i].st; clk_ready = q[i].cr;
            pay_valid = q[i].pv; pay_data = q[i].pd;
            #1;
            check(line_state == q[i].ls, q[i].rq, "line_state", line_state, q[i].ls);
            check(busy == q[i].bz, q[i].rq, "busy", busy, q[i].bz);
            check(pay_ready == q[i].rd, q[i].rq, "pay_ready", pay_ready, q[i].rd);
            check(hs_valid == q[i].vd, q[i].rq, "hs_valid", hs_valid, q[i].vd);
            if (q[i].vd)
                check(hs_byte == q[i].by, q[i].rq, "hs_byte", hs_byte, q[i].by);
        end
        start = 0; clk_ready = 0; pay_valid = 0; pay_data = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        cfg_trail = 8'd5; cfg_eot_max = 8'd20;
        repeat (3) @(negedge clk);
        #1;
        // R1 values while reset is held
        check(line_state == 3'd0, 1, "line_state in reset", line_state, 0);
        check(!busy && !pay_ready && !hs_valid, 1, "outputs in reset",
              {busy, pay_ready, hs_valid}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check(line_state == 3'd0 && !busy, 1, "idle after reset", {busy, line_state}, 0);
        // R10 configuration flag
        check(cfg_err == 1'b0, 10, "cfg_err 5<=20", cfg_err, 0);
        cfg_trail = 8'd9; cfg_eot_max = 8'd8; #1;
        check(cfg_err == 1'b1, 10, "cfg_err 9>8", cfg_err, 1);
        cfg_eot_max = 8'd9; #1;
        check(cfg_err == 1'b0, 10, "cfg_err 9<=9", cfg_err, 0);
        cfg_eot_max = 8'd40;

        run_burst(3, 2, 4, 5, 3, 3, 8'h11, 0, 0, 1'b0);   // trail after bit7 = 0
        run_burst(0, 1, 1, 1, 0, 1, 8'hA5, 3, 2, 1'b0);   // zero intervals, clock delay, stall
        run_burst(10, 7, 12, 9, 20, 6, 8'h02, 1, 0, 1'b1); // R11 start held high throughout

        finish_run();
    end
endmodule